// File: doc/BRIEF.md
# SPI FIFO Interrupt and Status Unit

This unit gathers the interrupt and FIFO status of an SPI peripheral with two 8-entry FIFOs, one for transmit and one for receive. It watches the occupancy count of each FIFO and a set of single-cycle event pulses. These pulses are overrun on either FIFO, transmit underrun, two wait-timer expiries, and two forms of transmit completion. Each condition is latched into a sticky status bit. A status bit that is set and also enabled drives a single interrupt line.

Software reaches the unit through a small register port. The control word holds the per-source enables, the two watermark codes, the completion-source select and two flush request bits. The status word holds the sticky bits, which are cleared by writing 1. It also holds the full and empty indications and the two occupancy counts. The FIFO storage and the serial engine sit outside this unit. The unit gives them only the flush strobes.

Each flush request runs through a two-state machine. The states are FL_IDLE and FL_ACTIVE. The machine goes from FL_IDLE to FL_ACTIVE on a write with the flush bit set. It goes from FL_ACTIVE back to FL_IDLE on the next clock.

Top module: `spi_irq_status_unit`

## Requirements
- R1: After reset, every status bit, enable, watermark code and select bit is 0. Both flush strobes are 0 and `irq` is 0.
- R2: Status bit 0 (TX watermark) sets when `tx_count` is greater than the TX code plus 1. The TX code is in control bits [10:8] and takes the values 0 to 7.
- R3: Status bit 1 (RX watermark) sets when `rx_count` is greater than the RX code plus 1. The RX code is in control bits [14:12].
- R4: A one-cycle pulse sets its sticky bit on the next clock, and the bit stays set after the pulse ends. The pulses map to status bits as follows: TX overrun to bit 2, RX overrun to bit 3, timer 0 to bit 5, timer 1 to bit 6, and TX underrun to bit 7.
- R5: A write to the status address (`reg_addr`=1) clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R6: If a source event arrives in the same cycle as a clear of its bit, the bit stays set.
- R7: `irq` is 1 exactly when some status bit [7:0] and its enable bit are both 1. The enables are control bits [7:0] (`reg_addr`=0).
- R8: `tx_not_full` and status bit 8 are 0 only when `tx_count` is 8. `rx_not_empty` and status bit 9 are 0 only when `rx_count` is 0.
- R9: Status bits [15:12] read `tx_count` and bits [19:16] read `rx_count`. Both are 4-bit values from 0 to 8.
- R10: A control write with bit 20 set makes `tx_flush` high for exactly one cycle after that clock. Bit 21 does the same for `rx_flush`. Each flush bit reads 1 only during its strobe and returns to 0 by itself.
- R11: Control bit 16 selects which pulse sets status bit 4 (TX complete). With bit 16 at 0, `tx_done` sets it. With bit 16 at 1, `tx_done_dma` sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tx_count | input | 4 | TX FIFO occupancy |
| rx_count | input | 4 | RX FIFO occupancy |
| tx_ovr | input | 1 | TX overrun pulse |
| rx_ovr | input | 1 | RX overrun pulse |
| tx_udr | input | 1 | TX underrun pulse |
| tim0_exp | input | 1 | Wait timer 0 pulse |
| tim1_exp | input | 1 | Wait timer 1 pulse |
| tx_done | input | 1 | Serial completion pulse |
| tx_done_dma | input | 1 | Completion including DMA TX |
| tx_flush | output | 1 | TX FIFO flush strobe |
| rx_flush | output | 1 | RX FIFO flush strobe |
| tx_not_full | output | 1 | 0 when TX FIFO full |
| rx_not_empty | output | 1 | 0 when RX FIFO empty |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision, where a source event and a write-1-to-clear of the same bit land on the same clock edge. The stimulus drives the overrun pulse and the status write on the same falling edge, so the rising edge captures both. It then repeats the clear with no event, which shows that the clear itself works. The watermark comparison is swept over every code with every occupancy from 0 to 8, on both FIFOs. Before each new point, the bit is removed by lowering the count and clearing.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int NSRC = 8;
    localparam int SRC_TXWM  = 0;
    localparam int SRC_RXWM  = 1;
    localparam int SRC_TXOVR = 2;
    localparam int SRC_RXOVR = 3;
    localparam int SRC_DONE  = 4;
    localparam int SRC_TIM0  = 5;
    localparam int SRC_TIM1  = 6;
    localparam int SRC_TXUDR = 7;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int CTL_TXWM_LSB = 8;
    localparam int CTL_RXWM_LSB = 12;
    localparam int CTL_SEL_BIT  = 16;
    localparam int CTL_TXFL_BIT = 20;
    localparam int CTL_RXFL_BIT = 21;

    localparam int ST_NFULL_BIT  = 8;
    localparam int ST_NEMPTY_BIT = 9;
    localparam int ST_TXCNT_LSB  = 12;
    localparam int ST_RXCNT_LSB  = 16;

    typedef enum logic {
        FL_IDLE   = 1'b0,
        FL_ACTIVE = 1'b1
    } flush_state_t;
endpackage

// File: rtl/spi_irq_flush_fsm.sv
module spi_irq_flush_fsm
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic strobe
);
    flush_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:   if (req) state_d = FL_ACTIVE;
            FL_ACTIVE: state_d = FL_IDLE;
            default:   state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_ACTIVE: strobe = 1'b1;
            default:   strobe = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_irq_wm_cmp.sv
module spi_irq_wm_cmp #(
    parameter int CNT_W = 4,
    parameter int WM_W  = 3
) (
    input  logic [CNT_W-1:0] count,
    input  logic [WM_W-1:0]  code,
    output logic             above
);
    logic [CNT_W-1:0] limit;
    always_comb begin
        limit = CNT_W'(code) + CNT_W'(1);
        above = (count > limit);
    end
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | evt;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en);
endmodule

// File: rtl/spi_irq_status_unit.sv
module spi_irq_status_unit
    import spi_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WM_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [3:0]  tx_count,
    input  logic [3:0]  rx_count,
    input  logic        tx_ovr,
    input  logic        rx_ovr,
    input  logic        tx_udr,
    input  logic        tim0_exp,
    input  logic        tim1_exp,
    input  logic        tx_done,
    input  logic        tx_done_dma,
    output logic        tx_flush,
    output logic        rx_flush,
    output logic        tx_not_full,
    output logic        rx_not_empty,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NSRC-1:0] en_q;
    logic [WM_W-1:0] tx_wm_q, rx_wm_q;
    logic            sel_q;
    logic            ctl_wr, st_wr;
    logic [1:0]      fl_req, fl_strobe;
    logic [NSRC-1:0] evt, clr, flags;
    logic            tx_above, rx_above;

    assign ctl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign st_wr  = reg_wr && (reg_addr == ADDR_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            tx_wm_q <= '0;
            rx_wm_q <= '0;
            sel_q   <= 1'b0;
        end else if (ctl_wr) begin
            en_q    <= reg_wdata[NSRC-1:0];
            tx_wm_q <= reg_wdata[CTL_TXWM_LSB +: WM_W];
            rx_wm_q <= reg_wdata[CTL_RXWM_LSB +: WM_W];
            sel_q   <= reg_wdata[CTL_SEL_BIT];
        end
    end

    assign fl_req[0] = ctl_wr && reg_wdata[CTL_TXFL_BIT];
    assign fl_req[1] = ctl_wr && reg_wdata[CTL_RXFL_BIT];

    for (genvar g = 0; g < 2; g++) begin : g_flush
        spi_irq_flush_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (fl_req[g]),
            .strobe (fl_strobe[g])
        );
    end

    assign tx_flush = fl_strobe[0];
    assign rx_flush = fl_strobe[1];

    spi_irq_wm_cmp #(.CNT_W(CNT_W), .WM_W(WM_W)) u_txwm (
        .count (tx_count[CNT_W-1:0]), .code (tx_wm_q), .above (tx_above));
    spi_irq_wm_cmp #(.CNT_W(CNT_W), .WM_W(WM_W)) u_rxwm (
        .count (rx_count[CNT_W-1:0]), .code (rx_wm_q), .above (rx_above));

    always_comb begin
        evt            = '0;
        evt[SRC_TXWM]  = tx_above;
        evt[SRC_RXWM]  = rx_above;
        evt[SRC_TXOVR] = tx_ovr;
        evt[SRC_RXOVR] = rx_ovr;
        evt[SRC_DONE]  = sel_q ? tx_done_dma : tx_done;
        evt[SRC_TIM0]  = tim0_exp;
        evt[SRC_TIM1]  = tim1_exp;
        evt[SRC_TXUDR] = tx_udr;
        clr            = st_wr ? reg_wdata[NSRC-1:0] : '0;
    end

    spi_irq_sticky #(.N(NSRC)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr),
        .en    (en_q),
        .flags (flags),
        .irq   (irq)
    );

    assign tx_not_full  = (tx_count[CNT_W-1:0] != CNT_W'(DEPTH));
    assign rx_not_empty = (rx_count[CNT_W-1:0] != '0);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[NSRC-1:0]                 = en_q;
                reg_rdata[CTL_TXWM_LSB +: WM_W]     = tx_wm_q;
                reg_rdata[CTL_RXWM_LSB +: WM_W]     = rx_wm_q;
                reg_rdata[CTL_SEL_BIT]              = sel_q;
                reg_rdata[CTL_TXFL_BIT]             = fl_strobe[0];
                reg_rdata[CTL_RXFL_BIT]             = fl_strobe[1];
            end
            default: begin
                reg_rdata[NSRC-1:0]                 = flags;
                reg_rdata[ST_NFULL_BIT]             = tx_not_full;
                reg_rdata[ST_NEMPTY_BIT]            = rx_not_empty;
                reg_rdata[ST_TXCNT_LSB +: CNT_W]    = tx_count[CNT_W-1:0];
                reg_rdata[ST_RXCNT_LSB +: CNT_W]    = rx_count[CNT_W-1:0];
            end
        endcase
    end
endmodule

module spi_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_addr,
    input logic [31:0] reg_wdata,
    input logic [7:0]  flags,
    input logic [7:0]  en,
    input logic        tx_ovr,
    input logic        tx_udr,
    input logic [3:0]  tx_count,
    input logic        tx_flush,
    input logic        rx_flush,
    input logic        tx_not_full,
    input logic        irq
);
    a_r4_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovr |=> flags[2]);
    a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !(reg_wr && reg_addr && reg_wdata[2])) |=> flags[2]);
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && reg_wdata[7] && !tx_udr) |=> !flags[7]);
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && reg_wdata[2] && tx_ovr) |=> flags[2]);
    a_r7_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & en) != 8'h00));
    a_r8_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == 4'd8) |-> !tx_not_full);
    a_r10_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> !tx_flush);
    a_r10_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_flush);
endmodule

bind spi_irq_status_unit spi_irq_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .flags       (flags),
    .en          (en_q),
    .tx_ovr      (tx_ovr),
    .tx_udr      (tx_udr),
    .tx_count    (tx_count),
    .tx_flush    (tx_flush),
    .rx_flush    (rx_flush),
    .tx_not_full (tx_not_full),
    .irq         (irq)
);

// File: tb/spi_irq_status_unit_bench.sv
module spi_irq_status_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tx_count = '0, rx_count = '0;
    logic        tx_ovr = 0, rx_ovr = 0, tx_udr = 0, tim0_exp = 0, tim1_exp = 0;
    logic        tx_done = 0, tx_done_dma = 0;
    logic        tx_flush, rx_flush, tx_not_full, rx_not_empty, irq;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_status_unit u_spi_irq_status_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(1'b0, d); chk("R1 ctrl", d, 32'h0);
        rd(1'b1, d); chk("R1 status", d[7:0], 8'h00);
        chk("R1 irq/flush", {irq, tx_flush, rx_flush}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 TX watermark sweep, R8/R9 TX side
        for (int code = 0; code < 8; code++) begin
            for (int cnt = 0; cnt <= 8; cnt++) begin
                wr(1'b0, 32'(code) << 8);
                tx_count = 4'(cnt);
                @(negedge clk);
                rd(1'b1, d);
                chk("R2 txwm", {31'h0, d[0]}, {31'h0, cnt > code + 1});
                chk("R9 txcnt", {28'h0, d[15:12]}, 32'(cnt));
                chk("R8 notfull", {30'h0, d[8], tx_not_full},
                    (cnt == 8) ? 32'h0 : 32'h3);
                tx_count = '0;
                wr(1'b1, 32'h1);
            end
        end

        // R3 RX watermark sweep, R8/R9 RX side
        for (int code = 0; code < 8; code++) begin
            for (int cnt = 0; cnt <= 8; cnt++) begin
                wr(1'b0, 32'(code) << 12);
                rx_count = 4'(cnt);
                @(negedge clk);
                rd(1'b1, d);
                chk("R3 rxwm", {31'h0, d[1]}, {31'h0, cnt > code + 1});
                chk("R9 rxcnt", {28'h0, d[19:16]}, 32'(cnt));
                chk("R8 notempty", {30'h0, d[9], rx_not_empty},
                    (cnt == 0) ? 32'h0 : 32'h3);
                rx_count = '0;
                wr(1'b1, 32'h2);
            end
        end
        wr(1'b1, 32'hFF);
        wr(1'b0, 32'h0);

        // R4 pulses set sticky bits and hold
        @(negedge clk); tx_ovr = 1; rx_ovr = 1;
        @(negedge clk); tx_ovr = 0; rx_ovr = 0; tim0_exp = 1;
        @(negedge clk); tim0_exp = 0; tim1_exp = 1; tx_udr = 1;
        @(negedge clk); tim1_exp = 0; tx_udr = 0;
        repeat (3) @(negedge clk);
        rd(1'b1, d); chk("R4 sticky", d[7:0], 8'hEC);

        // R5 write 0 no effect, partial clear
        wr(1'b1, 32'h0);
        rd(1'b1, d); chk("R5 write0", d[7:0], 8'hEC);
        wr(1'b1, 32'h24);
        rd(1'b1, d); chk("R5 partial", d[7:0], 8'hC8);

        // R7 irq masking over each single enable
        for (int b = 0; b < 8; b++) begin
            wr(1'b0, 32'h1 << b);
            chk("R7 irq", {31'h0, irq}, {31'h0, ((8'hC8 >> b) & 1) == 1});
        end
        wr(1'b0, 32'h0);
        wr(1'b1, 32'hFF);
        wr(1'b0, 32'h04);
        chk("R7 irq none", {31'h0, irq}, 32'h0);

        // R6 event beats clear
        @(negedge clk);
        tx_ovr = 1; reg_wr = 1; reg_addr = 1'b1; reg_wdata = 32'h4;
        @(negedge clk);
        tx_ovr = 0; reg_wr = 0; reg_wdata = '0;
        rd(1'b1, d); chk("R6 collide", {31'h0, d[2]}, 32'h1);
        chk("R7 irq set", {31'h0, irq}, 32'h1);
        wr(1'b1, 32'h4);
        rd(1'b1, d); chk("R6 then clear", {31'h0, d[2]}, 32'h0);

        // R11 completion select
        wr(1'b0, 32'h0);
        @(negedge clk); tx_done_dma = 1; @(negedge clk); tx_done_dma = 0;
        rd(1'b1, d); chk("R11 sel0 dma", {31'h0, d[4]}, 32'h0);
        @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
        rd(1'b1, d); chk("R11 sel0 done", {31'h0, d[4]}, 32'h1);
        wr(1'b1, 32'h10);
        wr(1'b0, 32'h1 << 16);
        @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
        rd(1'b1, d); chk("R11 sel1 done", {31'h0, d[4]}, 32'h0);
        @(negedge clk); tx_done_dma = 1; @(negedge clk); tx_done_dma = 0;
        rd(1'b1, d); chk("R11 sel1 dma", {31'h0, d[4]}, 32'h1);

        // R10 flush strobes
        chk("R10 idle", {30'h0, tx_flush, rx_flush}, 32'h0);
        wr(1'b0, 32'h1 << 20);
        rd(1'b0, d);
        chk("R10 tx strobe", {29'h0, tx_flush, rx_flush, d[20]}, 32'h5);
        @(negedge clk);
        rd(1'b0, d);
        chk("R10 tx back", {29'h0, tx_flush, rx_flush, d[20]}, 32'h0);
        wr(1'b0, 32'h1 << 21);
        rd(1'b0, d);
        chk("R10 rx strobe", {29'h0, tx_flush, rx_flush, d[21]}, 32'h3);
        @(negedge clk);
        rd(1'b0, d);
        chk("R10 rx back", {29'h0, tx_flush, rx_flush, d[21]}, 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule